// File: doc/BRIEF.md
# Function-Select ALU Slice with Carry Lookahead

A combinational arithmetic/logic slice of four bits. Four select lines and a mode bit choose among sixteen bitwise functions and sixteen arithmetic functions of two operands. Each slice forms its internal carries by lookahead. It offers a ripple carry out, so slices can be chained. It also offers a group propagate and a group generate, so a separate lookahead unit could combine several slices. An equality flag goes high when every result bit is one. With the subtract code this means the operands match. Read together with the carry out, it separates greater-than from less-than.

The top level places four slices in a carry ripple chain, giving a 16-bit datapath. All outputs pass through one rank of registers, so the block can be exercised with a clock. Operands are active high. The carry input and the carry output are active low: a low level means a carry is present.

Top module: `fsel_alu_chain`

## Requirements
- R1: Every output is registered. Values sampled at rising edge k appear at the outputs after edge k. mode_i=1 selects the bitwise function set and mode_i=0 selects the arithmetic set.
- R2: In bitwise mode, each result bit is a function of only a_i and b_i at that bit position, selected by sel_i as follows. 0:~a, 1:~(a|b), 2:~a&b, 3:0, 4:~(a&b), 5:~b, 6:a^b, 7:a&~b, 8:~a|b, 9:~(a^b), 10:b, 11:a&b, 12:1, 13:a|~b, 14:a|b, 15:a.
- R3: In bitwise mode, cn_n_i has no effect on f_o and aeb_o. The carry out still reports the arithmetic carry of the selected terms.
- R4: In arithmetic mode, each slice computes U + V + c, where c = ~cn_n (carry into the slice). The U and V operands by sel_i are:
  - 0: a, 0
  - 1: a|b, 0
  - 2: a|~b, 0
  - 3: 15, 0
  - 4: a, a&~b
  - 5: a|b, a&~b
  - 6: a|~b, a&~b
  - 7: 15, a&~b
  - 8: a, a&b
  - 9: a|b, a&b
  - 10: a|~b, a&b
  - 11: 15, a&b
  - 12: a, a
  - 13: a|b, a
  - 14: a|~b, a
  - 15: 15, a
- R5: A slice's carry out is low exactly when its U+V+c exceeds 15. With sel_i=6, cn_n_i=0 yields a-b, cn_n_i=1 yields a-b-1, and a low cn4_n_o means no borrow occurred.
- R6: For each slice k, grp_p_n_o[k] is low exactly when U is all ones. grp_g_n_o[k] is low exactly when U+V exceeds 15. Neither depends on cn_n_i.
- R7: aeb_o is high exactly when all 16 result bits are one.
- R8: Slices are chained from bit 0 upward through their carry outs. sel_i=9 gives the 17-bit sum {~cn4_n_o,f_o} = a+b+~cn_n. sel_i=6 with cn_n_i=0 gives f_o=a-b, and cn4_n_o low iff a>=b.
- R9: While rst_ni is low, the outputs are held at f_o=0, cn4_n_o=1, aeb_o=0, and both group vectors all ones, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| sel_i | input | 4 | Function select |
| mode_i | input | 1 | 1 = bitwise, 0 = arithmetic |
| cn_n_i | input | 1 | Carry into bit 0, active low |
| f_o | output | 16 | Registered result |
| cn4_n_o | output | 1 | Carry out of bit 15, active low |
| aeb_o | output | 1 | All result bits one |
| grp_p_n_o | output | 4 | Per-slice group propagate, active low |
| grp_g_n_o | output | 4 | Per-slice group generate, active low |

## Verification
The block holds no state between operations apart from the output rank. A wrong term, carry or select decode therefore shows up at the ports on the very next clock, for the vector that exposes it. The low slice is driven through every select, mode, operand pair and carry value, while the upper slices take varied operands. This means a fault in one lookahead product, or in a single function encoding, produces a mismatched result, carry or group flag in that cycle. Separate full-width add and subtract runs compare the chained result with direct 17-bit arithmetic. These runs expose any break in the ripple between slices.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_PASS  = 4'b0000;
  localparam sel_t SEL_SUB   = 4'b0110;
  localparam sel_t SEL_ADD   = 4'b1001;
  localparam sel_t SEL_ZERO  = 4'b0011;
  localparam sel_t SEL_ONES  = 4'b1100;
  localparam sel_t SEL_COPYA = 4'b1111;
endpackage

// File: rtl/fsel_alu_terms.sv
module fsel_alu_terms
  import fsel_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sel_t         sel_i,
  output logic [W-1:0] u_o,
  output logic [W-1:0] v_o
);
  // u: propagate-side operand, v: generate-side operand (v is a subset of a, a subset of u)
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign u_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    assign v_o[i] = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
  end
endmodule

// File: rtl/fsel_alu_lookahead.sv
module fsel_alu_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         cin_i,
  output logic [W:0]   c_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  assign c_o[0] = cin_i;

  // two-level sum of products per carry, no ripple
  for (genvar i = 0; i < W; i++) begin : g_cy
    logic gen_any;
    logic prop_all;
    always_comb begin
      gen_any  = 1'b0;
      prop_all = 1'b1;
      for (int j = i; j >= 0; j--) begin
        gen_any  = gen_any | (g_i[j] & prop_all);
        prop_all = prop_all & p_i[j];
      end
    end
    assign c_o[i+1] = gen_any | (prop_all & cin_i);
  end

  assign grp_g_o = g_cy[W-1].gen_any;
  assign grp_p_o = g_cy[W-1].prop_all;
endmodule

// File: rtl/fsel_alu_slice.sv
module fsel_alu_slice
  import fsel_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sel_t         sel_i,
  input  logic         mode_i,
  input  logic         cn_n_i,
  output logic [W-1:0] f_o,
  output logic         cout_n_o,
  output logic         grp_p_n_o,
  output logic         grp_g_n_o,
  output logic         eq_o
);
  logic [W-1:0] u, v;
  logic [W:0]   c;
  logic         gp, gg;
  logic [W-1:0] cin_eff;

  fsel_alu_terms #(.W(W)) u_terms (
    .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .u_o(u), .v_o(v)
  );

  fsel_alu_lookahead #(.W(W)) u_la (
    .p_i(u), .g_i(v), .cin_i(~cn_n_i), .c_o(c), .grp_p_o(gp), .grp_g_o(gg)
  );

  // bitwise mode: internal carries forced to the inactive level of the sum
  assign cin_eff   = mode_i ? {W{1'b1}} : c[W-1:0];
  assign f_o       = u ^ v ^ cin_eff;
  assign cout_n_o  = ~c[W];
  assign grp_p_n_o = ~gp;
  assign grp_g_n_o = ~gg;
  assign eq_o      = &f_o;
endmodule

// File: rtl/fsel_alu_chain.sv
module fsel_alu_chain
  import fsel_alu_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 4,
  localparam int DW      = SLICE_W * N_SLICES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW-1:0]       a_i,
  input  logic [DW-1:0]       b_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                mode_i,
  input  logic                cn_n_i,
  output logic [DW-1:0]       f_o,
  output logic                cn4_n_o,
  output logic                aeb_o,
  output logic [N_SLICES-1:0] grp_p_n_o,
  output logic [N_SLICES-1:0] grp_g_n_o
);
  logic [N_SLICES:0]   cy_n;
  logic [DW-1:0]       f_d;
  logic [N_SLICES-1:0] eq_d, p_d, g_d;

  assign cy_n[0] = cn_n_i;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    fsel_alu_slice #(.W(SLICE_W)) u_slice (
      .a_i      (a_i[k*SLICE_W +: SLICE_W]),
      .b_i      (b_i[k*SLICE_W +: SLICE_W]),
      .sel_i    (sel_i),
      .mode_i   (mode_i),
      .cn_n_i   (cy_n[k]),
      .f_o      (f_d[k*SLICE_W +: SLICE_W]),
      .cout_n_o (cy_n[k+1]),
      .grp_p_n_o(p_d[k]),
      .grp_g_n_o(g_d[k]),
      .eq_o     (eq_d[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_o       <= '0;
      cn4_n_o   <= 1'b1;
      aeb_o     <= 1'b0;
      grp_p_n_o <= '1;
      grp_g_n_o <= '1;
    end else begin
      f_o       <= f_d;
      cn4_n_o   <= cy_n[N_SLICES];
      aeb_o     <= &eq_d;  // wired-AND of slice flags
      grp_p_n_o <= p_d;
      grp_g_n_o <= g_d;
    end
  end
endmodule

// File: rtl/fsel_alu_chain_chk.sv
module fsel_alu_chain_chk
  import fsel_alu_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 4,
  localparam int DW      = SLICE_W * N_SLICES
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DW-1:0]       a_i,
  input logic [DW-1:0]       b_i,
  input logic [SEL_W-1:0]    sel_i,
  input logic                mode_i,
  input logic                cn_n_i,
  input logic [DW-1:0]       f_o,
  input logic                cn4_n_o,
  input logic                aeb_o,
  input logic [N_SLICES-1:0] grp_p_n_o,
  input logic [N_SLICES-1:0] grp_g_n_o
);
  logic vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= 1'b1;
  end

  a_r7_eq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (aeb_o == (f_o == {DW{1'b1}})));

  a_r2_logic_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && $past(mode_i) && $past(sel_i) == SEL_ZERO |-> f_o == '0);

  a_r2_logic_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && $past(mode_i) && $past(sel_i) == SEL_COPYA |-> f_o == $past(a_i));

  a_r4_pass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !$past(mode_i) && $past(sel_i) == SEL_PASS && $past(cn_n_i)
    |-> f_o == $past(a_i) && cn4_n_o);

  a_r8_add_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !$past(mode_i) && $past(sel_i) == SEL_ADD
    |-> {~cn4_n_o, f_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}
                           + (DW+1)'($past(!cn_n_i))));

  a_r5_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !$past(mode_i) && $past(sel_i) == SEL_SUB && !$past(cn_n_i)
    |-> f_o == DW'($past(a_i) - $past(b_i)) && (!cn4_n_o == ($past(a_i) >= $past(b_i))));

  a_r6_no_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !$past(mode_i) && $past(sel_i) == SEL_PASS |-> grp_g_n_o == '1);

  a_r6_full_prop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && $past(sel_i) == SEL_ZERO |-> grp_p_n_o == '0);
endmodule

bind fsel_alu_chain fsel_alu_chain_chk #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_chk (.*);

// File: tb/fsel_alu_chain_bench.sv
`timescale 1ns/1ps
module fsel_alu_chain_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [3:0]  sel_i = '0;
  logic        mode_i = 1'b0, cn_n_i = 1'b1;
  logic [15:0] f_o;
  logic        cn4_n_o, aeb_o;
  logic [3:0]  grp_p_n_o, grp_g_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsel_alu_chain u_fsel_alu_chain (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .mode_i(mode_i), .cn_n_i(cn_n_i), .f_o(f_o), .cn4_n_o(cn4_n_o),
    .aeb_o(aeb_o), .grp_p_n_o(grp_p_n_o), .grp_g_n_o(grp_g_n_o)
  );

  typedef struct packed {
    logic [15:0] f;
    logic        cn4_n;
    logic        aeb;
    logic [3:0]  pn;
    logic [3:0]  gn;
    logic        m;
    logic        cn;
    logic        wchk;
    logic [16:0] wide;
  } exp_t;
  exp_t q[$];

  // arithmetic operand pair per select (R4)
  function automatic void ops(input int s, input int a, input int b, output int ux, output int vy);
    int nb;
    nb = (~b) & 15;
    case (s)
      0:  begin ux = a;      vy = 0;      end
      1:  begin ux = a | b;  vy = 0;      end
      2:  begin ux = a | nb; vy = 0;      end
      3:  begin ux = 15;     vy = 0;      end
      4:  begin ux = a;      vy = a & nb; end
      5:  begin ux = a | b;  vy = a & nb; end
      6:  begin ux = a | nb; vy = a & nb; end
      7:  begin ux = 15;     vy = a & nb; end
      8:  begin ux = a;      vy = a & b;  end
      9:  begin ux = a | b;  vy = a & b;  end
      10: begin ux = a | nb; vy = a & b;  end
      11: begin ux = 15;     vy = a & b;  end
      12: begin ux = a;      vy = a;      end
      13: begin ux = a | b;  vy = a;      end
      14: begin ux = a | nb; vy = a;      end
      default: begin ux = 15; vy = a;     end
    endcase
  endfunction

  // bitwise table (R2)
  function automatic int lfn(input int s, input int a, input int b);
    int na, nb;
    na = (~a) & 15;
    nb = (~b) & 15;
    case (s)
      0:  return na;
      1:  return (~(a | b)) & 15;
      2:  return na & b;
      3:  return 0;
      4:  return (~(a & b)) & 15;
      5:  return nb;
      6:  return a ^ b;
      7:  return a & nb;
      8:  return na | b;
      9:  return (~(a ^ b)) & 15;
      10: return b;
      11: return a & b;
      12: return 15;
      13: return a | nb;
      14: return a | b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_check();
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.m ? (e.cn ? "R1 R2" : "R3") : "R1 R4", "f", int'(f_o), int'(e.f));
      chk("R5", "carry", int'(cn4_n_o), int'(e.cn4_n));
      chk("R7", "eq", int'(aeb_o), int'(e.aeb));
      chk("R6", "grp", int'({grp_p_n_o, grp_g_n_o}), int'({e.pn, e.gn}));
      if (e.wchk) chk("R8", "wide", int'({~cn4_n_o, f_o}), int'(e.wide));
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [3:0] s,
                       input logic m, input logic cn, input logic wchk, input logic [16:0] wide);
    exp_t e;
    int cin, an, bn, ux, vy, sm, fn;
    @(negedge clk);
    do_check();
    a_i = a; b_i = b; sel_i = s; mode_i = m; cn_n_i = cn;
    cin = cn ? 0 : 1;
    for (int k = 0; k < 4; k++) begin
      an = int'((a >> (4*k)) & 16'hf);
      bn = int'((b >> (4*k)) & 16'hf);
      ops(int'(s), an, bn, ux, vy);
      sm = ux + vy + cin;
      fn = m ? lfn(int'(s), an, bn) : (sm & 15);
      e.f[4*k +: 4] = fn[3:0];
      e.pn[k] = (ux != 15);
      e.gn[k] = !((ux + vy) > 15);
      cin = (sm > 15) ? 1 : 0;
    end
    e.cn4_n = (cin == 0);
    e.aeb   = (e.f == 16'hffff);
    e.m     = m;
    e.cn    = cn;
    e.wchk  = wchk;
    e.wide  = wide;
    q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    logic        rc;
    // R9: reset values, also with active inputs
    repeat (3) @(negedge clk);
    chk("R9", "f", int'(f_o), 0);
    chk("R9", "carry", int'(cn4_n_o), 1);
    chk("R9", "eq", int'(aeb_o), 0);
    chk("R9", "grp", int'({grp_p_n_o, grp_g_n_o}), 8'hff);
    a_i = 16'hffff; mode_i = 1'b1; sel_i = 4'hf;
    repeat (2) @(negedge clk);
    chk("R9", "f held", int'(f_o), 0);
    chk("R9", "eq held", int'(aeb_o), 0);
    rst_ni = 1'b1;

    // exhaustive low slice, varied upper slices (R1..R7)
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) begin
              ra = {12'($urandom_range(0, 4095)), 4'(a)};
              rb = {12'($urandom_range(0, 4095)), 4'(b)};
              apply(ra, rb, 4'(s), m[0], c[0], 1'b0, '0);
            end

    // equal operands under subtract: aeb high with no carry in (R7)
    for (int i = 0; i < 40; i++) begin
      ra = 16'($urandom);
      apply(ra, ra, 4'b0110, 1'b0, 1'b1, 1'b0, '0);
    end

    // full-width add and subtract against direct arithmetic (R8)
    for (int i = 0; i < 300; i++) begin
      ra = 16'($urandom);
      rb = (i % 10 == 0) ? ra : 16'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, 4'b1001, 1'b0, rc, 1'b1, {1'b0, ra} + {1'b0, rb} + 17'(!rc));
      apply(ra, rb, 4'b0110, 1'b0, 1'b0, 1'b1, {ra >= rb, 16'(ra - rb)});
    end
    apply(16'hffff, 16'h0001, 4'b1001, 1'b0, 1'b1, 1'b1, 17'h10000);
    apply(16'h0000, 16'h0001, 4'b0110, 1'b0, 1'b0, 1'b1, {1'b0, 16'hffff});

    // random mixed traffic
    for (int i = 0; i < 2000; i++)
      apply(16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'b0, '0);

    @(negedge clk);
    do_check();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule